// File: doc/BRIEF.md
# Decimal Ten's-Complement Adder-Subtractor

This block adds or subtracts two signed decimal numbers of a fixed digit count. Each operand is packed BCD, one 4-bit digit per nibble, with digit 0 in bits [3:0] and digit k in bits [4k+3:4k]. Signed values use ten's complement: a negative number is the digit-wise complement to nine of its magnitude plus one. A leading digit of 0-4 marks a non-negative value and 5-9 a negative one, so sign extension prepends 0 or 9.

One select input picks the operation. For a difference, every digit of the second operand is replaced by its nine's complement and the initial carry is forced to 1, which completes the ten's complement. Each digit computes generate and propagate terms for both operations directly from the raw input digits. The select picks one pair, and the pair feeds one shared decimal carry chain. Each digit then forms a binary sum of its two digits and incoming carry, and adds 6 when the chain says the digit carries out. Result, carry-out and signed overflow are registered once.

Top module: `bcd_tc_addsub`

## Requirements
- R1: While rst_n is low and on the first sample after reset, result, carry_out and overflow are all 0.
- R2: With op_sub = 0, result equals (A + B + carry_in) mod 10^N as BCD digits, and carry_out is 1 exactly when A + B + carry_in >= 10^N, with A and B read as unsigned N-digit decimals.
- R3: With op_sub = 1, result equals (A + (10^N - 1 - B) + 1) mod 10^N and carry_out is 1 exactly when A >= B (unsigned). carry_in has no effect on any output.
- R4: The subtrahend digit complement maps d to 9 - d for every digit 0-9 (0 to 9, 9 to 0). Subtracting 0 returns A with carry_out 1, and subtracting all nines returns A + 1 mod 10^N.
- R5: Every result digit lies in 0-9 whenever the inputs are valid BCD.
- R6: In addition, overflow is 1 exactly when the leading digits of A and B fall in the same sign class (0-4 or 5-9) and the leading result digit falls in the other class.
- R7: In subtraction, overflow uses the same rule with B's leading digit replaced by its nine's complement. This includes negating the most negative value (leading digit 5, all other digits 0), which cannot be represented and flags overflow.
- R8: A carry raised in digit 0 propagates through any run of digits whose sum is 9 (addition) or whose digits are equal (subtraction), up to carry_out.
- R9: Outputs reflect the inputs sampled at one rising clock edge and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sub | input | 1 | 1 = A - B, 0 = A + B |
| carry_in | input | 1 | Initial carry for addition; ignored in subtraction |
| opa | input | 4*DIGITS | Operand A, packed BCD |
| opb | input | 4*DIGITS | Operand B, packed BCD |
| result | output | 4*DIGITS | Registered BCD result |
| carry_out | output | 1 | Registered decimal carry out of the top digit |
| overflow | output | 1 | Registered signed overflow flag |

## Verification
All three outputs come from one register stage. A stimulus applied before rising edge k therefore appears on result, carry_out and overflow right after edge k and holds until edge k+1. The bench changes inputs on the falling edge, waits for the next rising edge, and samples one time unit later, before the inputs change again. Expected values come from integer arithmetic on the decoded operands and from the sign-class rule, never from the digit logic.

// File: rtl/bcd_tc_addsub.sv
module bcd_tc_addsub #(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_sub,
  input  logic                carry_in,
  input  logic [4*DIGITS-1:0] opa,
  input  logic [4*DIGITS-1:0] opb,
  output logic [4*DIGITS-1:0] result,
  output logic                carry_out,
  output logic                overflow
);
  localparam int W = 4 * DIGITS;

  logic [DIGITS:0] chain;
  logic [W-1:0]    sum_d;
  logic            ovf_d;

  assign chain[0] = op_sub | carry_in;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] da, db, db_nc, db_eff, corr;
    logic [4:0] pair, bin;
    logic       gen_add, prop_add, gen_sub, prop_sub, gen, prop;

    assign da    = opa[4*i +: 4];
    assign db    = opb[4*i +: 4];
    assign db_nc = 4'd9 - db;

    assign pair     = {1'b0, da} + {1'b0, db};
    assign gen_add  = pair > 5'd9;
    assign prop_add = pair == 5'd9;
    assign gen_sub  = da > db;
    assign prop_sub = da == db;

    assign gen  = op_sub ? gen_sub  : gen_add;
    assign prop = op_sub ? prop_sub : prop_add;
    assign chain[i+1] = gen | (prop & chain[i]);

    assign db_eff = op_sub ? db_nc : db;
    assign bin    = {1'b0, da} + {1'b0, db_eff} + {4'b0000, chain[i]};
    assign corr   = chain[i+1] ? bin[3:0] + 4'd6 : bin[3:0];
    assign sum_d[4*i +: 4] = corr;

    // R5
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result[4*i +: 4] <= 4'd9);
  end

  logic [3:0] lead_a, lead_b, lead_r;
  logic       neg_a, neg_b, neg_r;

  assign lead_a = opa[W-1 -: 4];
  assign lead_b = op_sub ? 4'd9 - opb[W-1 -: 4] : opb[W-1 -: 4];
  assign lead_r = sum_d[W-1 -: 4];
  assign neg_a  = lead_a >= 4'd5;
  assign neg_b  = lead_b >= 4'd5;
  assign neg_r  = lead_r >= 4'd5;
  assign ovf_d  = (neg_a == neg_b) && (neg_r != neg_a);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      carry_out <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      result    <= sum_d;
      carry_out <= chain[DIGITS];
      overflow  <= ovf_d;
    end
  end

  // R3
  sub_self_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sub && opa == opb) |=> (result == '0 && carry_out && !overflow));

  // R2
  add_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_sub && !carry_in && opb == '0) |=>
      (result == $past(opa) && !carry_out && !overflow));

  // R6
  ovf_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (($past(opa[W-1 -: 4]) >= 4'd5) != (result[W-1 -: 4] >= 4'd5)));

  // R4
  sub_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sub && opb == '0) |=> (result == $past(opa) && carry_out));
endmodule

// File: tb/test_bcd_tc_addsub.sv
module test_bcd_tc_addsub;
  localparam int CLK_PERIOD = 10;
  localparam int DIGITS = 4;
  localparam int W = 4 * DIGITS;
  localparam int MODV = 10000;

  logic clk = 0, rst_n = 0, op_sub = 0, carry_in = 0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] result;
  logic carry_out, overflow;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_tc_addsub #(.DIGITS(DIGITS)) i_bcd_tc_addsub (
    .clk(clk), .rst_n(rst_n), .op_sub(op_sub), .carry_in(carry_in),
    .opa(opa), .opb(opb), .result(result), .carry_out(carry_out),
    .overflow(overflow));

  function automatic logic [W-1:0] to_bcd(int v);
    logic [W-1:0] r = '0;
    for (int k = 0; k < DIGITS; k++) begin
      r[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, int a, int b, bit sub, bit cin);
    int be, c0, tot, s;
    bit na, nb, nr;
    @(negedge clk);
    opa = to_bcd(a); opb = to_bcd(b); op_sub = sub; carry_in = cin;
    be  = sub ? (MODV - 1 - b) : b;
    c0  = sub ? 1 : int'(cin);
    tot = a + be + c0;
    s   = tot % MODV;
    na  = (a / 1000) >= 5; nb = (be / 1000) >= 5; nr = (s / 1000) >= 5;
    @(posedge clk); #1;
    check({req, " result"}, result, to_bcd(s));
    check({req, " carry_out"}, W'(carry_out), W'(tot >= MODV));
    check({req, " overflow"}, W'(overflow), W'((na == nb) && (nr != na)));
  endtask

  task automatic t_reset();
    @(negedge clk);
    opa = to_bcd(1234); opb = to_bcd(5678); carry_in = 1;
    @(posedge clk); #1;
    check("R1 result in reset", result, '0);
    check("R1 flags in reset", W'({carry_out, overflow}), '0);
    @(negedge clk); rst_n = 1;
    opa = '0; opb = '0; carry_in = 0;
    @(posedge clk); #1;
    check("R1 first sample", result, '0);
    check("R1 first flags", W'({carry_out, overflow}), '0);
  endtask

  task automatic t_add();
    run_op("R2 add", 1234, 4321, 0, 0);
    run_op("R2 add cin", 1999, 1, 0, 1);
    run_op("R2 add wrap", 8765, 4321, 0, 0);
    run_op("R5 add digits", 4789, 135, 0, 1);
  endtask

  task automatic t_sub();
    run_op("R3 sub", 4321, 1234, 1, 0);
    run_op("R3 sub cin ignored", 4321, 1234, 1, 1);
    run_op("R3 sub negative", 100, 250, 1, 0);
    run_op("R3 sub negative cin", 100, 250, 1, 1);
  endtask

  task automatic t_nines();
    run_op("R4 minus zero", 3141, 0, 1, 0);
    run_op("R4 minus nines", 3141, 9999, 1, 0);
    run_op("R4 all digits", 9876, 123, 1, 1);
    run_op("R4 all digits rev", 123, 4567, 1, 0);
  endtask

  task automatic t_ripple();
    run_op("R8 add ripple", 9999, 1, 0, 0);
    run_op("R8 add ripple cin", 4545, 5454, 0, 1);
    run_op("R8 sub ripple", 7777, 7777, 1, 0);
  endtask

  task automatic t_overflow();
    run_op("R6 pos overflow", 4000, 2000, 0, 0);
    run_op("R6 neg overflow", 5000, 5000, 0, 0);
    run_op("R6 mixed no ovf", 4999, 5000, 0, 1);
    run_op("R7 sub overflow", 4000, 6000, 1, 0);
    run_op("R7 negate most negative", 0, 5000, 1, 0);
    run_op("R7 negate neighbour", 0, 5001, 1, 0);
  endtask

  task automatic t_hold();
    run_op("R9 capture", 2468, 1357, 0, 0);
    @(negedge clk);
    opa = to_bcd(1111); opb = to_bcd(2222); op_sub = 1;
    #1;
    check("R9 hold before edge", result, to_bcd(3825));
    @(posedge clk); #1;
    check("R9 after edge", result, to_bcd(8889));
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 40; k++) begin
      run_op("R5 sweep", (k * 2713 + 17) % MODV, (k * 4519 + 903) % MODV,
             k[0], k[1]);
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_add();
        t_sub();
        t_nines();
        t_ripple();
        t_overflow();
        t_hold();
        t_sweep();
      end
      begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule